// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one instruction operand into a storage address. The operand is a 16-bit field: a base-register selector in the top nibble and an unsigned 12-bit byte offset below it. A separate 4-bit index selector may also be supplied. The block has its own 16 x 32-bit general register file. It reads the selected registers and replaces any selector equal to zero with a constant zero. It then adds base, index and offset and keeps the low 24 bits as the address.

The same unit resolves branch-through-register operands. A branch selector of zero cancels the branch and ignores register zero. A nonzero selector enables the branch and yields the register's low 24 bits as the target. A target with bit 0 set breaks 2-byte instruction alignment and raises an error flag. The results pass through an output register stage by default (`REG_OUT = 1`), which gives one cycle of latency. The register file is written through a simple single write port.

Top module: `operand_addr_unit`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `out_valid`, `ea_addr`, `br_addr`, `br_en` and `spec_err` are all zero.
- R2: `ea_addr` equals (base term + index term + zero-extended offset) modulo 2^24. Each term is the full 32-bit register value.
- R3: `opnd[15:12]` selects the base register. A base selector of 0 contributes zero, whatever register 0 holds.
- R4: An index selector `idx_sel` of 0 contributes zero, whatever register 0 holds.
- R5: `opnd[11:0]` is an unsigned offset from 0 to 4095 that is added without sign extension.
- R6: Any carry out of bit 23 of the sum is discarded, so the address wraps.
- R7: `br_en` is 1 only when `br_req` is 1 and `br_sel` is nonzero. When `br_en` is 1, `br_addr` holds bits 23:0 of the selected register; otherwise `br_addr` is 0.
- R8: `spec_err` is 1 exactly when `br_en` is 1 and bit 0 of `br_addr` is 1.
- R9: The outputs present the result for the inputs sampled at a rising edge, starting after that edge. `out_valid` follows `in_valid` by one cycle. When `in_valid` is 0, the other outputs keep their previous values.
- R10: A register write with `wr_en` high takes effect at the clock edge. An operand sampled at that same edge still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register file write strobe |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Data to write |
| in_valid | input | 1 | Operand inputs are valid this cycle |
| opnd | input | 16 | Base selector [15:12], offset [11:0] |
| idx_sel | input | 4 | Index register selector |
| br_req | input | 1 | Operand is a branch-through-register |
| br_sel | input | 4 | Branch register selector |
| out_valid | output | 1 | Outputs carry a new result |
| ea_addr | output | 24 | Effective address |
| br_en | output | 1 | Branch enabled |
| br_addr | output | 24 | Branch target |
| spec_err | output | 1 | Odd branch target |

## Verification
The bench builds the block with its defaults: 16 registers of 32 bits, a 12-bit offset, a 24-bit address and the registered output stage. Because the address is narrower than the registers, loading all-ones values makes wrap-around past bit 23 easy to reach. With the registered stage, the same-edge write-versus-read ordering and the hold behaviour while `in_valid` is low become observable. Random register contents with both even and odd low bits reach the alignment error on the random branch operands.

// File: rtl/eag_pkg.sv
package eag_pkg;
  // Indices of the three register-read terms.
  localparam int NUM_TERMS = 3;
  localparam int T_BASE    = 0;
  localparam int T_INDEX   = 1;
  localparam int T_BRANCH  = 2;
endpackage

// File: rtl/eag_regfile.sv
module eag_regfile #(
  parameter int NREGS  = 16,
  parameter int DATA_W = 32,
  parameter int NRD    = 3,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [SEL_W-1:0]               wsel,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NRD-1:0][SEL_W-1:0]      rsel,
  output logic [NRD-1:0][DATA_W-1:0]     rdata
);
  logic [DATA_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[wsel] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[rsel[p]];
  end
endmodule

// File: rtl/eag_zero_gate.sv
module eag_zero_gate #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] rval,
  output logic [DATA_W-1:0] term
);
  // Selector zero means "no register": contributes a constant zero.
  assign term = (sel == '0) ? '0 : rval;
endmodule

// File: rtl/eag_sum.sv
module eag_sum #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int DISP_W = 12
) (
  input  logic [DATA_W-1:0] base_t,
  input  logic [DATA_W-1:0] index_t,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  logic [DATA_W-1:0] full;
  logic [DATA_W-1:0] disp_x;

  assign disp_x = DATA_W'(disp);
  assign full   = base_t + index_t + disp_x;
  // Only the low address bits are kept; higher carries vanish.
  assign addr   = full[ADDR_W-1:0];
endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import eag_pkg::*;
#(
  parameter int NREGS   = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 24,
  parameter int DISP_W  = 12,
  parameter bit REG_OUT = 1'b1,
  localparam int SEL_W  = $clog2(NREGS),
  localparam int OPND_W = SEL_W + DISP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              in_valid,
  input  logic [OPND_W-1:0] opnd,
  input  logic [SEL_W-1:0]  idx_sel,
  input  logic              br_req,
  input  logic [SEL_W-1:0]  br_sel,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              br_en,
  output logic [ADDR_W-1:0] br_addr,
  output logic              spec_err
);
  logic [NUM_TERMS-1:0][SEL_W-1:0]  rd_sel;
  logic [NUM_TERMS-1:0][DATA_W-1:0] rd_val;
  logic [NUM_TERMS-1:0][DATA_W-1:0] term;

  logic [ADDR_W-1:0] ea_c;
  logic [ADDR_W-1:0] br_addr_c;
  logic              br_en_c;
  logic              spec_c;

  assign rd_sel[T_BASE]   = opnd[OPND_W-1 -: SEL_W];
  assign rd_sel[T_INDEX]  = idx_sel;
  assign rd_sel[T_BRANCH] = br_sel;

  eag_regfile #(.NREGS(NREGS), .DATA_W(DATA_W), .NRD(NUM_TERMS)) rf_i (
    .clk   (clk),
    .we    (wr_en),
    .wsel  (wr_sel),
    .wdata (wr_data),
    .rsel  (rd_sel),
    .rdata (rd_val)
  );

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    eag_zero_gate #(.DATA_W(DATA_W), .SEL_W(SEL_W)) zg_i (
      .sel  (rd_sel[t]),
      .rval (rd_val[t]),
      .term (term[t])
    );
  end

  eag_sum #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) sum_i (
    .base_t  (term[T_BASE]),
    .index_t (term[T_INDEX]),
    .disp    (opnd[DISP_W-1:0]),
    .addr    (ea_c)
  );

  assign br_en_c   = br_req && (br_sel != '0);
  assign br_addr_c = br_en_c ? term[T_BRANCH][ADDR_W-1:0] : '0;
  assign spec_c    = br_en_c && br_addr_c[0];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        ea_addr   <= '0;
        br_en     <= 1'b0;
        br_addr   <= '0;
        spec_err  <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          ea_addr  <= ea_c;
          br_en    <= br_en_c;
          br_addr  <= br_addr_c;
          spec_err <= spec_c;
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid && !rst;
    assign ea_addr   = ea_c;
    assign br_en     = br_en_c;
    assign br_addr   = br_addr_c;
    assign spec_err  = spec_c;
  end
endmodule

// File: rtl/operand_addr_unit_chk.sv
module operand_addr_unit_chk #(
  parameter int SEL_W   = 4,
  parameter int DISP_W  = 12,
  parameter int ADDR_W  = 24,
  parameter bit REG_OUT = 1'b1,
  localparam int OPND_W = SEL_W + DISP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OPND_W-1:0] opnd,
  input logic [SEL_W-1:0]  idx_sel,
  input logic              br_req,
  input logic [SEL_W-1:0]  br_sel,
  input logic              out_valid,
  input logic [ADDR_W-1:0] ea_addr,
  input logic              br_en,
  input logic [ADDR_W-1:0] br_addr,
  input logic              spec_err
);
  logic [ADDR_W-1:0] disp_x;
  logic              no_regs;
  logic              br_zero;

  assign disp_x  = ADDR_W'(opnd[DISP_W-1:0]);
  assign no_regs = in_valid && (opnd[OPND_W-1 -: SEL_W] == '0) && (idx_sel == '0);
  assign br_zero = in_valid && br_req && (br_sel == '0);

  if (REG_OUT) begin : g_seq
    // R3, R4, R5: no registers selected -> address is the bare offset
    p_offset_only_r3: assert property (@(posedge clk) disable iff (rst)
      no_regs |=> ea_addr == $past(disp_x));

    // R7: zero branch selector suppresses the branch
    p_br_zero_r7: assert property (@(posedge clk) disable iff (rst)
      br_zero |=> !br_en && br_addr == '0);

    // R7: disabled branch carries a zero target
    p_br_idle_r7: assert property (@(posedge clk) disable iff (rst)
      !br_en |-> br_addr == '0);

    // R8: error only on an enabled odd target
    p_err_odd_r8: assert property (@(posedge clk) disable iff (rst)
      spec_err |-> br_en && br_addr[0]);

    // R9: valid follows input one cycle later
    p_valid_lag_r9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> out_valid == $past(in_valid));

    // R9: outputs hold while no operand arrives
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(ea_addr) && $stable(br_addr) && $stable(br_en) && $stable(spec_err));
  end else begin : g_comb
    always_comb begin
      if (!rst) begin
        // R8: error only on an enabled odd target
        a_err_odd_r8: assert (!spec_err || (br_en && br_addr[0]));
        // R7: disabled branch carries a zero target
        a_br_idle_r7: assert (br_en || br_addr == '0);
      end
    end
  end
endmodule

bind operand_addr_unit operand_addr_unit_chk #(
  .SEL_W(SEL_W), .DISP_W(DISP_W), .ADDR_W(ADDR_W), .REG_OUT(REG_OUT)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opnd(opnd), .idx_sel(idx_sel),
  .br_req(br_req), .br_sel(br_sel), .out_valid(out_valid), .ea_addr(ea_addr),
  .br_en(br_en), .br_addr(br_addr), .spec_err(spec_err)
);

// File: tb/operand_addr_unit_tb_top.sv
module operand_addr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [31:0] wr_data;
  logic        in_valid;
  logic [15:0] opnd;
  logic [3:0]  idx_sel;
  logic        br_req;
  logic [3:0]  br_sel;
  logic        out_valid;
  logic [23:0] ea_addr;
  logic        br_en;
  logic [23:0] br_addr;
  logic        spec_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] rf_m [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_addr_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .in_valid(in_valid), .opnd(opnd), .idx_sel(idx_sel), .br_req(br_req),
    .br_sel(br_sel), .out_valid(out_valid), .ea_addr(ea_addr), .br_en(br_en),
    .br_addr(br_addr), .spec_err(spec_err)
  );

  function automatic logic [31:0] term_of(input logic [3:0] s);
    return (s == 4'd0) ? 32'd0 : rf_m[s];
  endfunction

  function automatic logic [23:0] exp_ea(input logic [3:0] b, input logic [3:0] x,
                                         input logic [11:0] d);
    logic [31:0] s;
    s = term_of(b) + term_of(x) + {20'd0, d};
    return s[23:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] s, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    rf_m[s] = v;
  endtask

  // Present one operand, then check the registered result one edge later.
  task automatic run_op(input string req, input logic [3:0] b, input logic [11:0] d,
                        input logic [3:0] x, input logic br, input logic [3:0] bs);
    logic [23:0] e_ea, e_ba;
    logic        e_be;
    @(negedge clk);
    in_valid = 1'b1; opnd = {b, d}; idx_sel = x; br_req = br; br_sel = bs;
    e_ea = exp_ea(b, x, d);
    e_be = br && (bs != 4'd0);
    e_ba = e_be ? rf_m[bs][23:0] : 24'd0;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R9 valid"}, 32'(out_valid), 32'd1);
    check({req, " R2 ea"}, 32'(ea_addr), 32'(e_ea));
    check({req, " R7 br_en"}, 32'(br_en), 32'(e_be));
    check({req, " R7 br_addr"}, 32'(br_addr), 32'(e_ba));
    check({req, " R8 err"}, 32'(spec_err), 32'(e_be && e_ba[0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [23:0] hold_ea;
    seed = 32'd2024;
    void'($urandom(seed));
    rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0;
    in_valid = 0; opnd = 0; idx_sel = 0; br_req = 0; br_sel = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", 32'(out_valid), 0);
    check("R1 ea", 32'(ea_addr), 0);
    check("R1 br", 32'({br_en, spec_err}), 0);
    check("R1 br_addr", 32'(br_addr), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 32'({out_valid, br_en, spec_err}), 0);

    for (int i = 0; i < 16; i++) wr_reg(4'(i), $urandom);

    // R3, R4: register 0 holds junk but must not contribute
    wr_reg(4'd0, 32'hDEAD_BEEF);
    wr_reg(4'd3, 32'h0000_1000);
    run_op("R3 base0", 4'd0, 12'h123, 4'd3, 1'b0, 4'd0);
    check("R3 base0 value", 32'(ea_addr), 32'h001123);
    run_op("R4 idx0", 4'd3, 12'h001, 4'd0, 1'b0, 4'd0);
    check("R4 idx0 value", 32'(ea_addr), 32'h001001);
    run_op("R5 bare", 4'd0, 12'hFFF, 4'd0, 1'b0, 4'd0);
    check("R5 max offset", 32'(ea_addr), 32'h000FFF);

    // R6: wrap past bit 23
    wr_reg(4'd5, 32'hFFFF_FFFF);
    wr_reg(4'd6, 32'h00FF_F000);
    run_op("R6 wrap", 4'd5, 12'h002, 4'd0, 1'b0, 4'd0);
    check("R6 wrap value", 32'(ea_addr), 32'h000001);
    run_op("R6 wrap2", 4'd6, 12'hFFF, 4'd6, 1'b0, 4'd0);

    // R7, R8: branch register rules
    wr_reg(4'd7, 32'h1234_5679);
    run_op("R7 br0", 4'd1, 12'h0, 4'd0, 1'b1, 4'd0);
    check("R7 br0 off", 32'(br_en), 0);
    run_op("R8 odd", 4'd1, 12'h0, 4'd0, 1'b1, 4'd7);
    check("R8 odd err", 32'(spec_err), 1);
    run_op("R7 noreq", 4'd1, 12'h0, 4'd0, 1'b0, 4'd7);

    // R9: hold while in_valid is low
    hold_ea = ea_addr;
    @(negedge clk);
    opnd = 16'h3ABC; idx_sel = 4'd5;
    @(negedge clk);
    check("R9 no valid", 32'(out_valid), 0);
    check("R9 hold", 32'(ea_addr), 32'(hold_ea));

    // R10: write and read on the same edge sees the old value
    wr_reg(4'd9, 32'h0000_0100);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd9; wr_data = 32'h0000_0200;
    in_valid = 1'b1; opnd = {4'd9, 12'h000}; idx_sel = 0; br_req = 0; br_sel = 0;
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0;
    rf_m[9] = 32'h0000_0200;
    check("R10 old value", 32'(ea_addr), 32'h000100);
    run_op("R10 new", 4'd9, 12'h000, 4'd0, 1'b0, 4'd0);
    check("R10 new value", 32'(ea_addr), 32'h000200);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      if (n % 20 == 0) wr_reg(4'($urandom_range(0, 15)), $urandom);
      run_op("RND", 4'($urandom_range(0, 15)), 12'($urandom), 4'($urandom_range(0, 15)),
             1'($urandom), 4'($urandom_range(0, 15)));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule